// File: doc/BRIEF.md
# Banked Bus Decoder with Question-ROM Window

This block sits beside an 8-bit processor with a 16-bit address bus and separate memory and I/O cycles. It turns each memory cycle into one chip select and picks the matching byte for the read-data bus. Program ROM, a battery-backed work RAM, two 2 KB tile RAMs and a sound data byte each get their own select. Other registers are write-only: a sound command strobe and an 8-bit control register.

Every I/O read, at any port number, is served from a 256 KB question ROM. The full 16-bit port number becomes the low address bits. Bits 4:3 of the control register supply the top two bits, which pick one of four 64 KB banks. Bit 2 of the same register is passed to the video logic as the tile bank select. Once per frame, on the rising edge of vertical blank, the block sends the processor a one-cycle interrupt pulse. The pulse goes to the non-maskable line when the coin input is high, and to the maskable line otherwise.

After reset, if the work RAM reports that it holds no saved contents, the block writes zero to every word before it marks itself ready.

Top module: `qbd_top`

## Requirements
- R1: A memory read selects exactly one region and returns that region's byte: 0x0000-0x7FFF program ROM (rom_cs), 0x8000-0x87FF work RAM (nv_cs), 0xC000-0xC7FF foreground tile RAM (fg_cs), 0xE000-0xE7FF background tile RAM (bg_cs).
- R2: A memory read at an address that maps to no readable source returns 0xFF and asserts no select. This includes 0x8800, 0xC800, 0xE800, 0x9000 and 0xB800.
- R3: A memory write to 0x9000 loads cpu_wdata into the control register, and the new value appears on ctrl_o at the next clock edge. tile_bank always equals bit 2 of the register. Reset clears the register to 0x00.
- R4: A memory write to 0x9800, 0xA000 or 0xB801, or into program ROM space, asserts no select and leaves the control register unchanged. Any I/O write does the same.
- R5: An I/O read at port P asserts q_cs, drives q_addr = {ctrl[4:3], P} and returns q_rdata on cpu_rdata.
- R6: A memory read or write at 0xB000 asserts snd_cs, and a read returns snd_rdata. A memory write at 0xB800 asserts snd_cmd_stb.
- R7: On the first clock edge that sees vblank high after it was low, one of the two interrupt outputs goes high for exactly one cycle. nmi_pulse fires if coin is high at that edge, and irq_pulse fires otherwise.
- R8: If nv_blank is high at the first edge after reset, the block writes 0x00 to all 2048 work-RAM words, one per cycle at ascending addresses, while init_busy is high. Processor writes to the work RAM during that time are dropped.
- R9: If nv_blank is low at the first edge after reset, no work-RAM write occurs, the RAM keeps its contents and init_busy falls after that one edge.
- R10: nmi_pulse and irq_pulse are never high together, and holding vblank high produces no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address / port number |
| cpu_wdata | input | 8 | Processor write data |
| cpu_mreq | input | 1 | Memory cycle |
| cpu_iorq | input | 1 | I/O cycle |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data to processor |
| rom_cs | output | 1 | Program ROM select (reads only) |
| rom_rdata | input | 8 | Program ROM data |
| nv_cs | output | 1 | Work RAM select |
| nv_we | output | 1 | Work RAM write enable |
| nv_addr | output | 11 | Work RAM address |
| nv_wdata | output | 8 | Work RAM write data |
| nv_rdata | input | 8 | Work RAM read data |
| nv_blank | input | 1 | Work RAM holds no saved contents |
| init_busy | output | 1 | Post-reset RAM check/clear in progress |
| fg_cs | output | 1 | Foreground tile RAM select |
| fg_rdata | input | 8 | Foreground tile RAM data |
| bg_cs | output | 1 | Background tile RAM select |
| bg_rdata | input | 8 | Background tile RAM data |
| snd_cs | output | 1 | Sound data byte select |
| snd_rdata | input | 8 | Sound data read value |
| snd_cmd_stb | output | 1 | Sound command write strobe |
| bus_we | output | 1 | Memory write qualifier for the selected device |
| q_cs | output | 1 | Question ROM select |
| q_addr | output | 18 | Question ROM address |
| q_rdata | input | 8 | Question ROM data |
| ctrl_o | output | 8 | Control register value |
| tile_bank | output | 1 | Video tile bank select |
| vblank | input | 1 | Vertical blank |
| coin | input | 1 | Coin input |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| irq_pulse | output | 1 | Maskable interrupt pulse |

## Verification
Control-register corruption is visible on ctrl_o one edge after the offending write. It is also visible on the next I/O read, because q_addr then points into the wrong 64 KB bank. A decode fault appears in the same cycle as a wrong or doubled select, or as a wrong read byte. A fault in the interrupt edge tracking shows up within the frame as a missing, stretched or doubled pulse. A fault in the clear sequencer shows up at release as a wrong write count or as leftover non-zero RAM bytes.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
    typedef enum logic [1:0] {
        NV_CHECK = 2'd0,
        NV_CLEAR = 2'd1,
        NV_DONE  = 2'd2
    } nv_state_t;

    typedef struct packed {
        logic rom;
        logic nv;
        logic fg;
        logic bg;
        logic snd;
        logic cmd;
        logic qrom;
    } sel_t;
endpackage

// File: rtl/qbd_decode.sv
module qbd_decode
    import qbd_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int WIN_AW = 11,
    parameter logic [AW-1:0] NV_BASE   = 16'h8000,
    parameter logic [AW-1:0] FG_BASE   = 16'hC000,
    parameter logic [AW-1:0] BG_BASE   = 16'hE000,
    parameter logic [AW-1:0] CTRL_ADR  = 16'h9000,
    parameter logic [AW-1:0] SND_ADR   = 16'hB000,
    parameter logic [AW-1:0] CMD_ADR   = 16'hB800
) (
    input  logic [AW-1:0] addr,
    input  logic          mreq,
    input  logic          iorq,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] rom_rdata,
    input  logic [DW-1:0] nv_rdata,
    input  logic [DW-1:0] fg_rdata,
    input  logic [DW-1:0] bg_rdata,
    input  logic [DW-1:0] snd_rdata,
    input  logic [DW-1:0] q_rdata,
    output sel_t          sel,
    output logic          ctrl_we,
    output logic [DW-1:0] rdata
);
    localparam int HI = AW - 1;

    logic in_rom, in_nv, in_fg, in_bg, acc;

    always_comb begin
        acc    = mreq & (rd | wr);
        in_rom = ~addr[HI];
        in_nv  = addr[HI:WIN_AW] == NV_BASE[HI:WIN_AW];
        in_fg  = addr[HI:WIN_AW] == FG_BASE[HI:WIN_AW];
        in_bg  = addr[HI:WIN_AW] == BG_BASE[HI:WIN_AW];

        sel      = '0;
        sel.rom  = mreq & rd & in_rom;
        sel.nv   = acc & in_nv;
        sel.fg   = acc & in_fg;
        sel.bg   = acc & in_bg;
        sel.snd  = acc & (addr == SND_ADR);
        sel.cmd  = mreq & wr & (addr == CMD_ADR);
        sel.qrom = iorq & rd;
        ctrl_we  = mreq & wr & (addr == CTRL_ADR);

        rdata = '1;
        unique case (1'b1)
            sel.rom:           rdata = rom_rdata;
            sel.nv  && rd:     rdata = nv_rdata;
            sel.fg  && rd:     rdata = fg_rdata;
            sel.bg  && rd:     rdata = bg_rdata;
            sel.snd && rd:     rdata = snd_rdata;
            sel.qrom:          rdata = q_rdata;
            default:           rdata = '1;
        endcase
    end
endmodule

// File: rtl/qbd_irq_gen.sv
module qbd_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank,
    input  logic coin,
    output logic nmi_pulse,
    output logic irq_pulse
);
    typedef struct packed {
        logic vbl;
        logic nmi;
        logic irq;
    } irq_state_t;

    irq_state_t s_d, s_q;
    logic edge_seen;

    always_comb begin
        edge_seen = vblank & ~s_q.vbl;
        s_d.vbl   = vblank;
        s_d.nmi   = edge_seen & coin;
        s_d.irq   = edge_seen & ~coin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign nmi_pulse = s_q.nmi;
    assign irq_pulse = s_q.irq;

    // R7: each pulse lasts exactly one cycle and is not followed by the other
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pulse || irq_pulse) |=> !(nmi_pulse || irq_pulse));
    // R10: the two interrupt lines never fire together
    assert_irq_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_pulse && irq_pulse));
endmodule

// File: rtl/qbd_nv_clear.sv
module qbd_nv_clear
    import qbd_pkg::*;
#(
    parameter int NV_AW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_i,
    output logic             clearing,
    output logic             busy,
    output logic [NV_AW-1:0] clr_addr
);
    localparam logic [NV_AW-1:0] LAST = '1;

    typedef struct packed {
        nv_state_t        st;
        logic [NV_AW-1:0] addr;
    } clr_state_t;

    clr_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            NV_CHECK: begin
                s_d.addr = '0;
                s_d.st   = blank_i ? NV_CLEAR : NV_DONE;
            end
            NV_CLEAR: begin
                if (s_q.addr == LAST) s_d.st = NV_DONE;
                else                  s_d.addr = s_q.addr + 1'b1;
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: NV_CHECK, addr: '0};
        else        s_q <= s_d;
    end

    assign clearing = (s_q.st == NV_CLEAR);
    assign busy     = (s_q.st != NV_DONE);
    assign clr_addr = s_q.addr;

    // R8: the clear walks the RAM one ascending word per cycle
    assert_clear_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clearing && clr_addr != LAST) |=> (clearing && clr_addr == ($past(clr_addr) + 1'b1)));
    // R8: busy never returns once released
    assert_busy_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: rtl/qbd_top.sv
module qbd_top
    import qbd_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int NV_AW    = 11,
    parameter int BANK_W   = 2,
    parameter int BANK_LSB = 3,
    parameter int TILE_BIT = 2,
    localparam int QAW     = AW + BANK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [DW-1:0]    cpu_wdata,
    input  logic             cpu_mreq,
    input  logic             cpu_iorq,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    output logic [DW-1:0]    cpu_rdata,
    output logic             rom_cs,
    input  logic [DW-1:0]    rom_rdata,
    output logic             nv_cs,
    output logic             nv_we,
    output logic [NV_AW-1:0] nv_addr,
    output logic [DW-1:0]    nv_wdata,
    input  logic [DW-1:0]    nv_rdata,
    input  logic             nv_blank,
    output logic             init_busy,
    output logic             fg_cs,
    input  logic [DW-1:0]    fg_rdata,
    output logic             bg_cs,
    input  logic [DW-1:0]    bg_rdata,
    output logic             snd_cs,
    input  logic [DW-1:0]    snd_rdata,
    output logic             snd_cmd_stb,
    output logic             bus_we,
    output logic             q_cs,
    output logic [QAW-1:0]   q_addr,
    input  logic [DW-1:0]    q_rdata,
    output logic [DW-1:0]    ctrl_o,
    output logic             tile_bank,
    input  logic             vblank,
    input  logic             coin,
    output logic             nmi_pulse,
    output logic             irq_pulse
);
    sel_t             sel;
    logic             ctrl_we;
    logic             clearing;
    logic [NV_AW-1:0] clr_addr;
    logic [DW-1:0]    ctrl_d, ctrl_q;

    qbd_decode #(.AW(AW), .DW(DW), .WIN_AW(NV_AW)) u_decode (
        .addr      (cpu_addr),
        .mreq      (cpu_mreq),
        .iorq      (cpu_iorq),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .rom_rdata (rom_rdata),
        .nv_rdata  (nv_rdata),
        .fg_rdata  (fg_rdata),
        .bg_rdata  (bg_rdata),
        .snd_rdata (snd_rdata),
        .q_rdata   (q_rdata),
        .sel       (sel),
        .ctrl_we   (ctrl_we),
        .rdata     (cpu_rdata)
    );

    qbd_nv_clear #(.NV_AW(NV_AW)) u_nv_clear (
        .clk      (clk),
        .rst_n    (rst_n),
        .blank_i  (nv_blank),
        .clearing (clearing),
        .busy     (init_busy),
        .clr_addr (clr_addr)
    );

    qbd_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank    (vblank),
        .coin      (coin),
        .nmi_pulse (nmi_pulse),
        .irq_pulse (irq_pulse)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o      = ctrl_q;
    assign tile_bank   = ctrl_q[TILE_BIT];
    assign q_cs        = sel.qrom;
    assign q_addr      = {ctrl_q[BANK_LSB +: BANK_W], cpu_addr};
    assign rom_cs      = sel.rom;
    assign fg_cs       = sel.fg;
    assign bg_cs       = sel.bg;
    assign snd_cs      = sel.snd;
    assign snd_cmd_stb = sel.cmd;
    assign bus_we      = cpu_mreq & cpu_wr;

    assign nv_cs    = sel.nv | clearing;
    assign nv_we    = clearing | (sel.nv & cpu_wr & ~init_busy);
    assign nv_addr  = clearing ? clr_addr : cpu_addr[NV_AW-1:0];
    assign nv_wdata = clearing ? '0 : cpu_wdata;

    // R1: at most one select per bus cycle
    assert_single_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel.rom, sel.nv, sel.fg, sel.bg, sel.snd, sel.cmd, sel.qrom}));
    // R2: memory reads with no select float high
    assert_unmapped_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mreq && cpu_rd && !cpu_wr && !rom_cs && !nv_cs && !fg_cs && !bg_cs && !snd_cs)
            |-> cpu_rdata == '1);
    // R4: the control register moves only on its own write
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(ctrl_o));
    // R5: an I/O read always reaches the question ROM
    assert_io_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_iorq && cpu_rd) |-> (q_cs && cpu_rdata == q_rdata));
    // R8: no processor write lands while the clear runs
    assert_clear_owns_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clearing |-> (nv_wdata == '0 && nv_addr == clr_addr));
endmodule

// File: tb/qbd_top_tb.sv
`timescale 1ns/1ps
module qbd_top_tb;
    localparam real PERIOD = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_mreq = 1'b0, cpu_iorq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        rom_cs, nv_cs, nv_we, fg_cs, bg_cs, snd_cs, snd_cmd_stb, bus_we, q_cs;
    logic [10:0] nv_addr;
    logic [7:0]  nv_wdata, nv_rdata, q_rdata, ctrl_o;
    logic [17:0] q_addr;
    logic        nv_blank = 1'b1, init_busy, tile_bank;
    logic        vblank = 1'b0, coin = 1'b0, nmi_pulse, irq_pulse;

    logic [7:0] nv_mem [2048];
    int checks = 0, errors = 0, clr_writes = 0;
    logic count_en = 1'b0;
    logic [7:0] exp_ctrl = 8'h00;

    always #(PERIOD/2) clk = ~clk;

    // memory models
    assign nv_rdata = nv_mem[nv_addr];
    assign q_rdata  = q_addr[7:0] ^ {6'd0, q_addr[17:16]};
    always @(posedge clk) begin
        if (nv_cs && nv_we) nv_mem[nv_addr] <= nv_wdata;
        if (count_en && nv_cs && nv_we) clr_writes <= clr_writes + 1;
    end

    qbd_top u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_mreq(cpu_mreq), .cpu_iorq(cpu_iorq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .rom_cs(rom_cs), .rom_rdata(8'h11),
        .nv_cs(nv_cs), .nv_we(nv_we), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
        .nv_rdata(nv_rdata), .nv_blank(nv_blank), .init_busy(init_busy),
        .fg_cs(fg_cs), .fg_rdata(8'h33), .bg_cs(bg_cs), .bg_rdata(8'h44),
        .snd_cs(snd_cs), .snd_rdata(8'h55), .snd_cmd_stb(snd_cmd_stb), .bus_we(bus_we),
        .q_cs(q_cs), .q_addr(q_addr), .q_rdata(q_rdata), .ctrl_o(ctrl_o),
        .tile_bank(tile_bank), .vblank(vblank), .coin(coin),
        .nmi_pulse(nmi_pulse), .irq_pulse(irq_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        cpu_mreq = 0; cpu_iorq = 0; cpu_rd = 0; cpu_wr = 0;
    endtask

    // vector: {kind[1:0] (0 mem rd,1 mem wr,2 io rd,3 io wr), addr, wdata, exp_data, exp_sel}
    // exp_sel bits: 6 rom, 5 nv, 4 fg, 3 bg, 2 snd, 1 cmd, 0 qrom
    localparam int NV = 29;
    localparam logic [40:0] VEC [NV] = '{
        {2'd0, 16'h0000, 8'h00, 8'h11, 7'h40},  // R1
        {2'd0, 16'h7FFF, 8'h00, 8'h11, 7'h40},  // R1
        {2'd0, 16'h8000, 8'h00, 8'h00, 7'h20},  // R1 cleared RAM
        {2'd0, 16'h87FF, 8'h00, 8'h00, 7'h20},  // R1
        {2'd0, 16'h8800, 8'h00, 8'hFF, 7'h00},  // R2
        {2'd0, 16'hC000, 8'h00, 8'h33, 7'h10},  // R1
        {2'd0, 16'hC7FF, 8'h00, 8'h33, 7'h10},  // R1
        {2'd0, 16'hC800, 8'h00, 8'hFF, 7'h00},  // R2
        {2'd0, 16'hE123, 8'h00, 8'h44, 7'h08},  // R1
        {2'd0, 16'hE800, 8'h00, 8'hFF, 7'h00},  // R2
        {2'd0, 16'hB000, 8'h00, 8'h55, 7'h04},  // R6
        {2'd0, 16'hB800, 8'h00, 8'hFF, 7'h00},  // R2
        {2'd0, 16'h9000, 8'h00, 8'hFF, 7'h00},  // R2
        {2'd1, 16'h8005, 8'h5A, 8'h00, 7'h20},  // R1 write
        {2'd0, 16'h8005, 8'h00, 8'h5A, 7'h20},  // R1 readback
        {2'd1, 16'hB000, 8'h21, 8'h00, 7'h04},  // R6
        {2'd1, 16'hB800, 8'h80, 8'h00, 7'h02},  // R6
        {2'd1, 16'h9000, 8'h1C, 8'h00, 7'h00},  // R3
        {2'd2, 16'h1234, 8'h00, 8'h00, 7'h01},  // R5 bank 3
        {2'd1, 16'h9800, 8'hFF, 8'h00, 7'h00},  // R4
        {2'd1, 16'hA000, 8'hFF, 8'h00, 7'h00},  // R4
        {2'd1, 16'hB801, 8'hFF, 8'h00, 7'h00},  // R4
        {2'd1, 16'h0100, 8'hFF, 8'h00, 7'h00},  // R4 ROM write
        {2'd3, 16'h9000, 8'hFF, 8'h00, 7'h00},  // R4 I/O write
        {2'd2, 16'hFFFF, 8'h00, 8'h00, 7'h01},  // R5
        {2'd1, 16'h9000, 8'h08, 8'h00, 7'h00},  // R3 bank 1
        {2'd2, 16'h0000, 8'h00, 8'h00, 7'h01},  // R5
        {2'd1, 16'h9000, 8'h00, 8'h00, 7'h00},  // R3 bank 0
        {2'd2, 16'hABCD, 8'h00, 8'h00, 7'h01}   // R5
    };

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < 2048; i++) nv_mem[i] = 8'hAA;
        repeat (3) @(negedge clk);
        // reset state
        chk("R3 reset ctrl", 32'(ctrl_o), 32'h00);
        chk("R3 reset tile_bank", 32'(tile_bank), 32'h0);
        chk("R7 reset pulses", 32'({nmi_pulse, irq_pulse}), 32'h0);

        // R8 clear after reset with blank RAM
        count_en = 1;
        rst_n = 1;
        begin
            int cyc = 0;
            while (init_busy && cyc < 3000) begin
                @(negedge clk);
                cyc++;
                if (cyc == 100) begin
                    cpu_mreq = 1; cpu_wr = 1; cpu_addr = 16'h8010; cpu_wdata = 8'h77;
                end else if (cyc == 101) begin
                    bus_idle();
                end
            end
            chk("R8 busy cycles", 32'(cyc), 32'd2049);
        end
        count_en = 0;
        chk("R8 clear write count", 32'(clr_writes), 32'd2048);
        begin
            int nz = 0;
            for (int i = 0; i < 2048; i++) if (nv_mem[i] !== 8'h00) nz++;
            chk("R8 non-zero words after clear", 32'(nz), 32'd0);
        end
        chk("R8 dropped cpu write", 32'(nv_mem[16]), 32'h00);

        // vector table
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  kind;
            logic [15:0] a;
            logic [7:0]  wd, ed;
            logic [6:0]  es;
            {kind, a, wd, ed, es} = VEC[v];
            @(negedge clk);
            cpu_addr = a; cpu_wdata = wd;
            cpu_mreq = (kind < 2); cpu_iorq = (kind >= 2);
            cpu_rd = (kind == 0) || (kind == 2);
            cpu_wr = (kind == 1) || (kind == 3);
            #1;
            chk($sformatf("R1/R4/R6 selects vec %0d", v),
                32'({rom_cs, nv_cs, fg_cs, bg_cs, snd_cs, snd_cmd_stb, q_cs}), 32'(es));
            if (kind == 0) chk($sformatf("R1/R2 rdata vec %0d", v), 32'(cpu_rdata), 32'(ed));
            if (kind == 2) begin
                chk($sformatf("R5 q_addr vec %0d", v), 32'(q_addr), 32'({exp_ctrl[4:3], a}));
                chk($sformatf("R5 rdata vec %0d", v), 32'(cpu_rdata),
                    32'(a[7:0] ^ {6'd0, exp_ctrl[4:3]}));
            end
            if (kind == 1 && a == 16'h9000) exp_ctrl = wd;
            @(posedge clk);
            #1;
            bus_idle();
            @(negedge clk);
            chk($sformatf("R3/R4 ctrl vec %0d", v), 32'(ctrl_o), 32'(exp_ctrl));
            chk($sformatf("R3 tile_bank vec %0d", v), 32'(tile_bank), 32'(exp_ctrl[2]));
        end

        // R7 coin high -> NMI
        @(negedge clk); coin = 1; vblank = 1;
        @(negedge clk);
        chk("R7 nmi on coin", 32'({nmi_pulse, irq_pulse}), 32'h2);
        @(negedge clk);
        chk("R10 no repeat while vblank high", 32'({nmi_pulse, irq_pulse}), 32'h0);
        repeat (3) @(negedge clk);
        chk("R10 still quiet", 32'({nmi_pulse, irq_pulse}), 32'h0);
        vblank = 0; coin = 0;
        @(negedge clk);
        chk("R7 falling vblank quiet", 32'({nmi_pulse, irq_pulse}), 32'h0);
        vblank = 1;
        @(negedge clk);
        chk("R7 irq without coin", 32'({nmi_pulse, irq_pulse}), 32'h1);
        @(negedge clk);
        chk("R7 irq one cycle", 32'({nmi_pulse, irq_pulse}), 32'h0);
        vblank = 0;

        // R9 reset with saved contents
        @(negedge clk);
        cpu_mreq = 1; cpu_wr = 1; cpu_addr = 16'h9000; cpu_wdata = 8'h04;
        @(negedge clk); bus_idle();
        rst_n = 0; nv_blank = 0;
        repeat (2) @(negedge clk);
        chk("R3 ctrl cleared by reset", 32'(ctrl_o), 32'h00);
        clr_writes = 0; count_en = 1;
        rst_n = 1;
        @(negedge clk);
        chk("R9 busy released", 32'(init_busy), 32'h0);
        repeat (3) @(negedge clk);
        count_en = 0;
        chk("R9 no writes", 32'(clr_writes), 32'd0);
        chk("R9 contents kept", 32'(nv_mem[5]), 32'h5A);

        summary();
    end
endmodule